// File: doc/BRIEF.md
# System Control Port Register Bank

A byte-wide bank of system control and identification ports on an ISA-style I/O bus. A host issues single-cycle read or write strobes with a 16-bit port address and an 8-bit write byte. The bank claims a sparse set of ports. Fixed identity bytes describe the board. Control ports drive level outputs: byte-order mode, disk activity light, a 4-bit system control field and an I/O map mode. Other ports emit one-cycle pulses: a soft-reset request and two NVRAM lock toggles. Two scratch bytes give software plain storage.

Each read strobe on a claimed port is answered one cycle later with `rd_data` and a `rd_valid` flag. The bus cannot stall, so there is no ready signal and no back-pressure. Every strobe is taken in the cycle it is presented, and a result the host does not collect in its `rd_valid` cycle is lost. Writes complete in the cycle of the strobe. Unclaimed addresses are left to other devices on the bus. For them the bank raises no `rd_valid` and holds `rd_data` at 0x00.

Top module: `sysport_bank`

## Requirements
- R1: A write to port 0x0092 raises `soft_rst_req` for the one cycle after the write when data bit 0 is 1. The same write loads data bit 1 into `le_mode`. A read of 0x0092 returns 0x00.
- R2: A write to port 0x0808 loads data bit 0 into `disk_led`. The other data bits are ignored.
- R3: A write to 0x0810 pulses `nv_lock1_pulse`, and a write to 0x0812 pulses `nv_lock2_pulse`. Each pulse lasts one cycle after the write, and the two are never high together.
- R4: A write to 0x081C stores data bits 3:0 in `sys_ctl`. A read of 0x081C returns that value, with bits 7:4 as 0.
- R5: A write to 0x0850 stores data bit 0 in `io_map_mode`. A read of 0x0850 returns that bit in bit 0, with the other bits 0.
- R6: Identity reads return fixed bytes: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x080C gives 0x3C, 0x0810 gives 0x39, 0x0818 gives 0x00 and 0x0823 gives 0x03. Writes to 0x0800, 0x0802, 0x0803 and 0x0814 change no output and no read value.
- R7: A read of any other address from 0x0800 to 0x0851 returns 0xFF. This includes 0x0808, 0x0812 and 0x0814.
- R8: Ports 0x0398 and 0x0399 are two independent read/write bytes, selected by the address minus 0x0398.
- R9: An address outside 0x0800..0x0851, 0x0092 and 0x0398..0x0399 is not claimed. A read there leaves `rd_valid` at 0 and `rd_data` at 0x00, and a write there changes nothing.
- R10: A synchronous active-high `rst` clears every stored bit, both scratch bytes, the pulses and the read outputs to 0.
- R11: `rd_data` and `rd_valid` are registered and appear one cycle after the read strobe. A read and a write in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | Port address |
| io_wdata | input | 8 | Write byte |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| rd_data | output | 8 | Registered read byte, 0x00 when no claimed read |
| rd_valid | output | 1 | High one cycle after a claimed read |
| soft_rst_req | output | 1 | One-cycle soft-reset request |
| le_mode | output | 1 | Little-endian mode flag |
| disk_led | output | 1 | Disk activity light |
| nv_lock1_pulse | output | 1 | One-cycle NVRAM lock toggle 1 |
| nv_lock2_pulse | output | 1 | One-cycle NVRAM lock toggle 2 |
| sys_ctl | output | 4 | System control field |
| io_map_mode | output | 1 | I/O map mode bit |

## Verification
Every result of this bank is due exactly one clock edge after the strobe that causes it. This covers read bytes, `rd_valid`, level outputs and pulses alike. The bench therefore drives one strobe per cycle on the falling edge. At the next rising edge it advances a behavioural model of the ports, then compares all outputs against that model shortly after the edge. Because every cycle is compared, the one-cycle width of the pulses is checked by the idle cycles that follow them. The same-cycle read-before-write ordering is checked by issuing both strobes together.

// File: rtl/sysport_pkg.sv
package sysport_pkg;

  typedef enum logic [3:0] {
    P_NONE,
    P_SPECIAL,
    P_SCRATCH,
    P_ID_CPU,
    P_ID_FEAT,
    P_ID_STAT,
    P_LIGHT,
    P_ID_EQUIP,
    P_LOCK1,
    P_LOCK2,
    P_ID_KEY,
    P_SYSCTL,
    P_ID_CACHE,
    P_MAPMODE,
    P_HOLE
  } port_e;

  localparam int unsigned A_SPECIAL  = 32'h0092;
  localparam int unsigned A_SCR_BASE = 32'h0398;
  localparam int unsigned A_RANGE_LO = 32'h0800;
  localparam int unsigned A_RANGE_HI = 32'h0851;
  localparam int unsigned A_ID_CPU   = 32'h0800;
  localparam int unsigned A_ID_FEAT  = 32'h0802;
  localparam int unsigned A_ID_STAT  = 32'h0803;
  localparam int unsigned A_LIGHT    = 32'h0808;
  localparam int unsigned A_ID_EQUIP = 32'h080C;
  localparam int unsigned A_LOCK1    = 32'h0810;
  localparam int unsigned A_LOCK2    = 32'h0812;
  localparam int unsigned A_ID_KEY   = 32'h0818;
  localparam int unsigned A_SYSCTL   = 32'h081C;
  localparam int unsigned A_ID_CACHE = 32'h0823;
  localparam int unsigned A_MAPMODE  = 32'h0850;

  localparam int unsigned V_ID_CPU   = 32'hEF;
  localparam int unsigned V_ID_FEAT  = 32'hAD;
  localparam int unsigned V_ID_STAT  = 32'hE0;
  localparam int unsigned V_ID_EQUIP = 32'h3C;
  localparam int unsigned V_ID_LOCK1 = 32'h39;
  localparam int unsigned V_ID_KEY   = 32'h00;
  localparam int unsigned V_ID_CACHE = 32'h03;

endpackage

// File: rtl/sysport_decode.sv
module sysport_decode
  import sysport_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int SCRATCH_N = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output port_e             sel
);

  always_comb begin
    sel = P_NONE;
    if (addr == ADDR_W'(A_SPECIAL)) begin
      sel = P_SPECIAL;
    end else if (addr >= ADDR_W'(A_SCR_BASE) &&
                 addr <  ADDR_W'(A_SCR_BASE + SCRATCH_N)) begin
      sel = P_SCRATCH;
    end else if (addr >= ADDR_W'(A_RANGE_LO) && addr <= ADDR_W'(A_RANGE_HI)) begin
      if      (addr == ADDR_W'(A_ID_CPU))   sel = P_ID_CPU;
      else if (addr == ADDR_W'(A_ID_FEAT))  sel = P_ID_FEAT;
      else if (addr == ADDR_W'(A_ID_STAT))  sel = P_ID_STAT;
      else if (addr == ADDR_W'(A_LIGHT))    sel = P_LIGHT;
      else if (addr == ADDR_W'(A_ID_EQUIP)) sel = P_ID_EQUIP;
      else if (addr == ADDR_W'(A_LOCK1))    sel = P_LOCK1;
      else if (addr == ADDR_W'(A_LOCK2))    sel = P_LOCK2;
      else if (addr == ADDR_W'(A_ID_KEY))   sel = P_ID_KEY;
      else if (addr == ADDR_W'(A_SYSCTL))   sel = P_SYSCTL;
      else if (addr == ADDR_W'(A_ID_CACHE)) sel = P_ID_CACHE;
      else if (addr == ADDR_W'(A_MAPMODE))  sel = P_MAPMODE;
      else                                  sel = P_HOLE;
    end
  end

endmodule

// File: rtl/sysport_regs.sv
module sysport_regs
  import sysport_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CTL_W     = 4,
  parameter int SCRATCH_N = 2,
  localparam int SIDX_W   = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  port_e                         sel,
  input  logic [SIDX_W-1:0]             sidx,
  input  logic [DATA_W-1:0]             wdata,
  output logic                          soft_rst_req,
  output logic                          le_mode,
  output logic                          disk_led,
  output logic                          lock1,
  output logic                          lock2,
  output logic [CTL_W-1:0]              sys_ctl,
  output logic                          map_mode,
  output logic [SCRATCH_N*DATA_W-1:0]   scratch
);

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_rst_req <= 1'b0;
      lock1        <= 1'b0;
      lock2        <= 1'b0;
      le_mode      <= 1'b0;
      disk_led     <= 1'b0;
      sys_ctl      <= '0;
      map_mode     <= 1'b0;
    end else begin
      soft_rst_req <= wr && (sel == P_SPECIAL) && wdata[0];
      lock1        <= wr && (sel == P_LOCK1);
      lock2        <= wr && (sel == P_LOCK2);
      if (wr) begin
        case (sel)
          P_SPECIAL: le_mode  <= wdata[1];
          P_LIGHT:   disk_led <= wdata[0];
          P_SYSCTL:  sys_ctl  <= wdata[CTL_W-1:0];
          P_MAPMODE: map_mode <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < SCRATCH_N; g++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst)
        scratch[g*DATA_W +: DATA_W] <= '0;
      else if (wr && sel == P_SCRATCH && sidx == SIDX_W'(g))
        scratch[g*DATA_W +: DATA_W] <= wdata;
    end
  end

  // R1
  soft_req_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == P_SPECIAL && wdata[0]) |=> soft_rst_req);
  // R3
  lock_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({lock1, lock2}));
  // R4
  ctl_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == P_SYSCTL) |=> sys_ctl == $past(wdata[CTL_W-1:0]));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable({le_mode, disk_led, sys_ctl, map_mode, scratch}));

endmodule

// File: rtl/sysport_rdmux.sv
module sysport_rdmux
  import sysport_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CTL_W     = 4,
  parameter int SCRATCH_N = 2,
  localparam int SIDX_W   = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1
) (
  input  port_e                        sel,
  input  logic [SIDX_W-1:0]            sidx,
  input  logic [CTL_W-1:0]             sys_ctl,
  input  logic                         map_mode,
  input  logic [SCRATCH_N*DATA_W-1:0]  scratch,
  output logic [DATA_W-1:0]            rdata,
  output logic                         claim
);

  always_comb begin
    claim = (sel != P_NONE);
    case (sel)
      P_SPECIAL:  rdata = '0;
      P_SCRATCH:  rdata = scratch[sidx*DATA_W +: DATA_W];
      P_ID_CPU:   rdata = DATA_W'(V_ID_CPU);
      P_ID_FEAT:  rdata = DATA_W'(V_ID_FEAT);
      P_ID_STAT:  rdata = DATA_W'(V_ID_STAT);
      P_ID_EQUIP: rdata = DATA_W'(V_ID_EQUIP);
      P_LOCK1:    rdata = DATA_W'(V_ID_LOCK1);
      P_ID_KEY:   rdata = DATA_W'(V_ID_KEY);
      P_SYSCTL:   rdata = {{(DATA_W-CTL_W){1'b0}}, sys_ctl};
      P_ID_CACHE: rdata = DATA_W'(V_ID_CACHE);
      P_MAPMODE:  rdata = {{(DATA_W-1){1'b0}}, map_mode};
      P_NONE:     rdata = '0;
      default:    rdata = '1;
    endcase
  end

endmodule

// File: rtl/sysport_bank.sv
module sysport_bank
  import sysport_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CTL_W     = 4,
  parameter int SCRATCH_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              soft_rst_req,
  output logic              le_mode,
  output logic              disk_led,
  output logic              nv_lock1_pulse,
  output logic              nv_lock2_pulse,
  output logic [CTL_W-1:0]  sys_ctl,
  output logic              io_map_mode
);

  localparam int SIDX_W = (SCRATCH_N > 1) ? $clog2(SCRATCH_N) : 1;

  port_e                       sel;
  logic [SIDX_W-1:0]           sidx;
  logic [SCRATCH_N*DATA_W-1:0] scratch;
  logic [DATA_W-1:0]           mux_data;
  logic                        claim;

  assign sidx = io_addr[SIDX_W-1:0];

  sysport_decode #(.ADDR_W(ADDR_W), .SCRATCH_N(SCRATCH_N)) u_dec (
    .addr (io_addr),
    .sel  (sel)
  );

  sysport_regs #(.DATA_W(DATA_W), .CTL_W(CTL_W), .SCRATCH_N(SCRATCH_N)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .wr           (io_wr),
    .sel          (sel),
    .sidx         (sidx),
    .wdata        (io_wdata),
    .soft_rst_req (soft_rst_req),
    .le_mode      (le_mode),
    .disk_led     (disk_led),
    .lock1        (nv_lock1_pulse),
    .lock2        (nv_lock2_pulse),
    .sys_ctl      (sys_ctl),
    .map_mode     (io_map_mode),
    .scratch      (scratch)
  );

  sysport_rdmux #(.DATA_W(DATA_W), .CTL_W(CTL_W), .SCRATCH_N(SCRATCH_N)) u_mux (
    .sel      (sel),
    .sidx     (sidx),
    .sys_ctl  (sys_ctl),
    .map_mode (io_map_mode),
    .scratch  (scratch),
    .rdata    (mux_data),
    .claim    (claim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= io_rd && claim;
      rd_data  <= (io_rd && claim) ? mux_data : '0;
    end
  end

  // R11
  rd_timing_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(io_rd));
  // R9
  idle_data_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> rd_data == '0);
  // R1
  special_read_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == ADDR_W'(A_SPECIAL)) |=> (rd_valid && rd_data == '0));

endmodule

// File: tb/tb_sysport_bank.sv
`timescale 1ns/1ps
module tb_sysport_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid, soft_rst_req, le_mode, disk_led;
  logic        nv_lock1_pulse, nv_lock2_pulse, io_map_mode;
  logic [3:0]  sys_ctl;

  always #2.5 clk = ~clk;

  sysport_bank dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .rd_data(rd_data), .rd_valid(rd_valid),
    .soft_rst_req(soft_rst_req), .le_mode(le_mode), .disk_led(disk_led),
    .nv_lock1_pulse(nv_lock1_pulse), .nv_lock2_pulse(nv_lock2_pulse),
    .sys_ctl(sys_ctl), .io_map_mode(io_map_mode)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural model state
  bit       m_le, m_led, m_map;
  bit [3:0] m_ctl;
  bit [7:0] m_scr [2];
  bit [18:0] exp_v;

  function automatic bit claimed(input int a);
    return a == 'h92 || a == 'h398 || a == 'h399 || (a >= 'h800 && a <= 'h851);
  endfunction

  function automatic bit [7:0] model_read(input int a);
    case (a)
      'h92:  return 8'h00;
      'h398: return m_scr[0];
      'h399: return m_scr[1];
      'h800: return 8'hEF;
      'h802: return 8'hAD;
      'h803: return 8'hE0;
      'h80C: return 8'h3C;
      'h810: return 8'h39;
      'h818: return 8'h00;
      'h81C: return {4'h0, m_ctl};
      'h823: return 8'h03;
      'h850: return {7'h0, m_map};
      default: return 8'hFF;
    endcase
  endfunction

  task automatic step(input bit r, input bit w, input int a, input bit [7:0] d,
                      input string tag);
    bit ev; bit [7:0] ed; bit es, e1, e2;
    bit [18:0] act;
    @(negedge clk);
    io_rd = r; io_wr = w; io_addr = a[15:0]; io_wdata = d;
    @(posedge clk);
    if (rst) begin
      ev = 0; ed = 0; es = 0; e1 = 0; e2 = 0;
      m_le = 0; m_led = 0; m_map = 0; m_ctl = 0; m_scr[0] = 0; m_scr[1] = 0;
    end else begin
      ev = r && claimed(a);
      ed = ev ? model_read(a) : 8'h00;
      es = w && a == 'h92 && d[0];
      e1 = w && a == 'h810;
      e2 = w && a == 'h812;
      if (w) begin
        case (a)
          'h92:  m_le = d[1];
          'h808: m_led = d[0];
          'h81C: m_ctl = d[3:0];
          'h850: m_map = d[0];
          'h398: m_scr[0] = d;
          'h399: m_scr[1] = d;
          default: ;
        endcase
      end
    end
    exp_v = {ev, ed, es, m_le, m_led, e1, e2, m_ctl, m_map};
    #1;
    act = {rd_valid, rd_data, soft_rst_req, le_mode, disk_led,
           nv_lock1_pulse, nv_lock2_pulse, sys_ctl, io_map_mode};
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s addr=%h rd=%0d wr=%0d: actual=%h expected=%h",
               tag, a[15:0], r, w, act, exp_v);
    end
  endtask

  task automatic rd(input int a, input string tag);
    step(1, 0, a, 8'h00, tag);
  endtask
  task automatic wr(input int a, input bit [7:0] d, input string tag);
    step(0, 1, a, d, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 0, 8'h00, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R10 reset state
    rst = 1;
    repeat (3) idle("R10");
    rst = 0;
    idle("R10");

    // R1 special port
    wr('h92, 8'h03, "R1");
    idle("R1");
    rd('h92, "R1");
    wr('h92, 8'h00, "R1");
    wr('h92, 8'h02, "R1");
    wr('h92, 8'h01, "R1");
    idle("R1");

    // R2 light
    wr('h808, 8'h01, "R2");
    wr('h808, 8'hFE, "R2");
    wr('h808, 8'hFF, "R2");

    // R3 lock pulses
    wr('h810, 8'h00, "R3");
    wr('h812, 8'h00, "R3");
    idle("R3");
    wr('h812, 8'hFF, "R3");
    wr('h812, 8'hFF, "R3");
    idle("R3");

    // R4 system control
    wr('h81C, 8'hA5, "R4");
    rd('h81C, "R4");
    wr('h81C, 8'hFA, "R4");
    rd('h81C, "R4");

    // R5 map mode
    wr('h850, 8'hFF, "R5");
    rd('h850, "R5");
    wr('h850, 8'h02, "R5");
    rd('h850, "R5");

    // R6 identity bytes and ignored writes
    foreach (m_scr[i]) begin end
    rd('h800, "R6"); rd('h802, "R6"); rd('h803, "R6"); rd('h80C, "R6");
    rd('h810, "R6"); rd('h818, "R6"); rd('h823, "R6");
    wr('h800, 8'h00, "R6"); wr('h802, 8'hFF, "R6");
    wr('h803, 8'h11, "R6"); wr('h814, 8'hFF, "R6");
    rd('h800, "R6"); rd('h802, "R6"); rd('h803, "R6"); rd('h814, "R6");
    rd('h81C, "R6"); rd('h850, "R6");

    // R7 holes
    rd('h801, "R7"); rd('h808, "R7"); rd('h812, "R7");
    rd('h814, "R7"); rd('h851, "R7");
    for (int a = 'h800; a <= 'h851; a++) rd(a, "R7");

    // R8 scratch bytes
    wr('h398, 8'h5A, "R8");
    wr('h399, 8'hC3, "R8");
    rd('h398, "R8");
    rd('h399, "R8");
    wr('h398, 8'h0F, "R8");
    rd('h399, "R8");
    rd('h398, "R8");

    // R9 unclaimed
    rd('h852, "R9"); rd('h7FF, "R9"); rd('h93, "R9");
    rd('h397, "R9"); rd('h39A, "R9"); rd('hF800, "R9");
    wr('h852, 8'hFF, "R9"); wr('h39A, 8'hFF, "R9");
    wr('h091, 8'hFF, "R9"); wr('h1850, 8'h00, "R9");
    rd('h398, "R9"); rd('h399, "R9"); rd('h850, "R9");

    // R11 simultaneous read and write returns old value
    step(1, 1, 'h81C, 8'h07, "R11");
    rd('h81C, "R11");
    step(1, 1, 'h399, 8'h99, "R11");
    rd('h399, "R11");
    rd('h800, "R11");
    idle("R11");

    // R10 reset after state was set
    rst = 1;
    idle("R10");
    rst = 0;
    rd('h398, "R10"); rd('h399, "R10"); rd('h81C, "R10"); rd('h850, "R10");
    idle("R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule